// File: doc/BRIEF.md
# Runtime-Framed Serial Transceiver

This block sends and receives asynchronous serial frames on a single-wire line that idles high. Each frame begins with one low start bit, carries a programmable number of data bits with the least significant first, and ends with a programmable number of high stop bits. The bit period is a whole number of system clock cycles set by a divisor input. The host reaches the block through two byte-wide request/acknowledge channels. Received bytes are offered on one channel and held until the host takes them. Bytes to send are offered on the other channel and the block acknowledges each one as it takes it.

The receiver passes the line through a two-flop synchroniser. On the first low level it waits half a bit period and checks the line again. If the line has gone high, the event is treated as noise. Otherwise each data bit is sampled at its centre, and the first stop bit is checked. A loopback control routes the transmitter's line into the receiver in place of the external input, so a link can be tested without wiring. The framing settings are taken at the start of each frame. A zero in any setting selects its default.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, ser_out is high, rx_req is low and tx_ack is low.
- R2: When the transmitter is idle and tx_req is high, it takes tx_byte and raises tx_ack for exactly one cycle. Starting in that same cycle, ser_out sends one low start bit, then the data bits least significant first, then the stop bits at high level. Each bit lasts the effective divisor in clock cycles.
- R3: The effective settings are resolved as follows. For the divisor, 0 selects 5208 and 1 to 3 select 4. For the data-bit count, 0 selects 8 and any value above 8 selects 8. For the stop-bit count, 0 selects 1. Each side captures the settings when a frame begins.
- R4: The receiver samples each data bit at its centre and assembles the bits least significant first. After a frame with a valid stop bit, it raises rx_req with the byte on rx_data.
- R5: While rx_req is high and rx_ack is low, rx_req stays high and rx_data stays unchanged. A frame that completes during this time is dropped.
- R6: When rx_ack is high while rx_req is high, rx_req is low in the next cycle.
- R7: With fewer than 8 data bits, the unused upper bits of rx_data are zero.
- R8: A low level on the line that ends before half a bit period has passed is ignored, and no byte is delivered.
- R9: If the first stop bit is sampled low, the frame is discarded and rx_req stays low.
- R10: With loop_en high, the receiver listens to the transmitter's own line, and ser_in has no effect. ser_out still carries the transmitted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | External serial line into the receiver |
| ser_out | output | 1 | Serial line driven by the transmitter |
| loop_en | input | 1 | Route the transmitter's line into the receiver |
| cfg_div | input | 16 | Clock cycles per serial bit (0 selects the default) |
| cfg_nbits | input | 4 | Data bits per frame (0 selects 8) |
| cfg_nstop | input | 2 | Stop bits per frame (0 selects 1) |
| rx_req | output | 1 | A received byte is waiting |
| rx_data | output | 8 | Received byte, right aligned |
| rx_ack | input | 1 | Host takes the waiting byte |
| tx_req | input | 1 | Host offers a byte to send |
| tx_byte | input | 8 | Byte to send |
| tx_ack | output | 1 | One-cycle pulse when the byte is taken |

## Verification
The assertions assume two things about the inputs. First, the host lowers tx_req within one cycle after it sees tx_ack. Second, cfg_nbits is not changed while a received frame is in flight, because the check on the upper bits of rx_data compares against the live setting. The stimulus changes framing settings only between frames, with both sides idle. It drops tx_req on the first sampling point after the acknowledge. It returns ser_in high before it clears loop_en, so that leaving loopback does not create a false start edge.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
    typedef enum logic [1:0] {
        LS_IDLE  = 2'd0,
        LS_START = 2'd1,
        LS_DATA  = 2'd2,
        LS_STOP  = 2'd3
    } line_state_e;
endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_xcvr_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int NB_W   = 4,
    parameter int NS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic [NB_W-1:0]   nbits,
    input  logic [NS_W-1:0]   nstop,
    input  logic              req,
    input  logic [DATA_W-1:0] data,
    output logic              ack,
    output logic              line
);
    localparam logic [DIV_W-1:0] ONE_D = 1;
    localparam logic [NB_W-1:0]  ONE_B = 1;
    localparam logic [NS_W-1:0]  ONE_S = 1;

    typedef struct packed {
        line_state_e       state;
        logic [DIV_W-1:0]  cnt;
        logic [DIV_W-1:0]  dv;
        logic [DATA_W-1:0] sh;
        logic [NB_W-1:0]   bits;
        logic [NS_W-1:0]   stops;
        logic              line;
        logic              ack;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        unique case (st_q.state)
            LS_IDLE: begin
                st_d.line = 1'b1;
                if (req && !st_q.ack) begin
                    st_d.state = LS_START;
                    st_d.sh    = data;
                    st_d.bits  = nbits - ONE_B;
                    st_d.stops = nstop - ONE_S;
                    st_d.dv    = div;
                    st_d.cnt   = div - ONE_D;
                    st_d.line  = 1'b0;
                    st_d.ack   = 1'b1;
                end
            end
            LS_START: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE_D;
                end else begin
                    st_d.state = LS_DATA;
                    st_d.line  = st_q.sh[0];
                    st_d.sh    = st_q.sh >> 1;
                    st_d.cnt   = st_q.dv - ONE_D;
                end
            end
            LS_DATA: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE_D;
                end else if (st_q.bits == '0) begin
                    st_d.state = LS_STOP;
                    st_d.line  = 1'b1;
                    st_d.cnt   = st_q.dv - ONE_D;
                end else begin
                    st_d.bits = st_q.bits - ONE_B;
                    st_d.line = st_q.sh[0];
                    st_d.sh   = st_q.sh >> 1;
                    st_d.cnt  = st_q.dv - ONE_D;
                end
            end
            LS_STOP: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE_D;
                end else if (st_q.stops == '0) begin
                    st_d.state = LS_IDLE;
                end else begin
                    st_d.stops = st_q.stops - ONE_S;
                    st_d.cnt   = st_q.dv - ONE_D;
                end
            end
            default: st_d.state = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= LS_IDLE;
            st_q.line  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack  = st_q.ack;
    assign line = st_q.line;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_xcvr_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int NB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic [DIV_W-1:0]  div,
    input  logic [NB_W-1:0]   nbits,
    output logic              req,
    output logic [DATA_W-1:0] data,
    input  logic              ack
);
    localparam logic [DIV_W-1:0] ONE_D = 1;
    localparam logic [NB_W-1:0]  ONE_B = 1;

    typedef struct packed {
        line_state_e       state;
        logic [DIV_W-1:0]  cnt;
        logic [DIV_W-1:0]  dv;
        logic [DATA_W-1:0] sh;
        logic [NB_W-1:0]   bits;
        logic [NB_W-1:0]   nb;
        logic              req;
        logic [DATA_W-1:0] data;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.req && ack) st_d.req = 1'b0;
        unique case (st_q.state)
            LS_IDLE: begin
                if (!line) begin
                    st_d.state = LS_START;
                    st_d.dv    = div;
                    st_d.nb    = nbits;
                    st_d.bits  = nbits - ONE_B;
                    st_d.cnt   = (div >> 1) - ONE_D;
                end
            end
            LS_START: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE_D;
                end else if (line) begin
                    st_d.state = LS_IDLE;
                end else begin
                    st_d.state = LS_DATA;
                    st_d.sh    = '0;
                    st_d.cnt   = st_q.dv - ONE_D;
                end
            end
            LS_DATA: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE_D;
                end else begin
                    st_d.sh  = {line, st_q.sh[DATA_W-1:1]};
                    st_d.cnt = st_q.dv - ONE_D;
                    if (st_q.bits == '0) st_d.state = LS_STOP;
                    else                 st_d.bits  = st_q.bits - ONE_B;
                end
            end
            LS_STOP: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE_D;
                end else begin
                    st_d.state = LS_IDLE;
                    if (line && !st_q.req) begin
                        st_d.req  = 1'b1;
                        st_d.data = st_q.sh >> (DATA_W - int'(st_q.nb));
                    end
                end
            end
            default: st_d.state = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= LS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req  = st_q.req;
    assign data = st_q.data;
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr #(
    parameter int DIV_W       = 16,
    parameter int DATA_W      = 8,
    parameter int NB_W        = 4,
    parameter int NS_W        = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DEF_DIV     = 5208,
    parameter int DEF_NBITS   = 8,
    parameter int DEF_NSTOP   = 1,
    parameter int MIN_DIV     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic              ser_out,
    input  logic              loop_en,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [NB_W-1:0]   cfg_nbits,
    input  logic [NS_W-1:0]   cfg_nstop,
    output logic              rx_req,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_ack,
    input  logic              tx_req,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_ack
);
    localparam logic [DIV_W-1:0] DEF_DIV_L = DIV_W'(DEF_DIV);
    localparam logic [DIV_W-1:0] MIN_DIV_L = DIV_W'(MIN_DIV);
    localparam logic [NB_W-1:0]  DEF_NB_L  = NB_W'(DEF_NBITS);
    localparam logic [NB_W-1:0]  MAX_NB_L  = NB_W'(DATA_W);
    localparam logic [NS_W-1:0]  DEF_NS_L  = NS_W'(DEF_NSTOP);

    logic [DIV_W-1:0] eff_div;
    logic [NB_W-1:0]  eff_nb;
    logic [NS_W-1:0]  eff_ns;
    logic             tx_line, rx_raw, rx_line;

    always_comb begin
        if (cfg_div == '0)            eff_div = DEF_DIV_L;
        else if (cfg_div < MIN_DIV_L) eff_div = MIN_DIV_L;
        else                          eff_div = cfg_div;

        if (cfg_nbits == '0)           eff_nb = DEF_NB_L;
        else if (cfg_nbits > MAX_NB_L) eff_nb = MAX_NB_L;
        else                           eff_nb = cfg_nbits;

        eff_ns = (cfg_nstop == '0) ? DEF_NS_L : cfg_nstop;
    end

    assign rx_raw  = loop_en ? tx_line : ser_in;
    assign ser_out = tx_line;

    uart_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_raw),
        .d_out (rx_line)
    );

    uart_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W), .NB_W(NB_W), .NS_W(NS_W)) tx_i (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (eff_div),
        .nbits (eff_nb),
        .nstop (eff_ns),
        .req   (tx_req),
        .data  (tx_byte),
        .ack   (tx_ack),
        .line  (tx_line)
    );

    uart_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W), .NB_W(NB_W)) rx_i (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (rx_line),
        .div   (eff_div),
        .nbits (eff_nb),
        .req   (rx_req),
        .data  (rx_data),
        .ack   (rx_ack)
    );
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk #(
    parameter int DATA_W = 8,
    parameter int NB_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_out,
    input logic [NB_W-1:0]   cfg_nbits,
    input logic              rx_req,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ack,
    input logic              tx_req,
    input logic              tx_ack
);
    localparam logic [NB_W-1:0] FULL_NB = NB_W'(DATA_W);

    a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && !rx_ack) |=> (rx_req && $stable(rx_data)));

    a_r6_rx_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && rx_ack) |=> !rx_req);

    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |=> !tx_ack);

    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> $past(tx_req));

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> !ser_out);

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_req) && cfg_nbits != '0 && cfg_nbits < FULL_NB)
            |-> ((rx_data >> cfg_nbits) == '0));
endmodule

bind uart_xcvr uart_xcvr_chk #(.DATA_W(DATA_W), .NB_W(NB_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_out   (ser_out),
    .cfg_nbits (cfg_nbits),
    .rx_req    (rx_req),
    .rx_data   (rx_data),
    .rx_ack    (rx_ack),
    .tx_req    (tx_req),
    .tx_ack    (tx_ack)
);

// File: tb/uart_xcvr_tb_top.sv
module uart_xcvr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b1;
    logic        ser_out;
    logic        loop_en = 1'b0;
    logic [15:0] cfg_div = 16'd8;
    logic [3:0]  cfg_nbits = 4'd8;
    logic [1:0]  cfg_nstop = 2'd1;
    logic        rx_req;
    logic [7:0]  rx_data;
    logic        rx_ack = 1'b0;
    logic        tx_req = 1'b0;
    logic [7:0]  tx_byte = 8'h00;
    logic        tx_ack;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    uart_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(ser_out),
        .loop_en(loop_en), .cfg_div(cfg_div), .cfg_nbits(cfg_nbits),
        .cfg_nstop(cfg_nstop), .rx_req(rx_req), .rx_data(rx_data),
        .rx_ack(rx_ack), .tx_req(tx_req), .tx_byte(tx_byte), .tx_ack(tx_ack)
    );

    function automatic logic [7:0] masked(input logic [7:0] v, input int nb);
        return v & 8'((1 << nb) - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] v, input int nb, input int ns,
                              input int dv, input bit stop_ok);
        ser_in = 1'b0; cyc(dv);
        for (int i = 0; i < nb; i++) begin ser_in = v[i]; cyc(dv); end
        ser_in = stop_ok; cyc(dv);
        ser_in = 1'b1;
        if (ns > 1) cyc(dv * (ns - 1));
    endtask

    task automatic wait_rx(input int limit, output bit got);
        got = 1'b0;
        for (int i = 0; i < limit && !got; i++) begin
            if (rx_req) got = 1'b1; else @(negedge clk);
        end
    endtask

    task automatic take_rx(input logic [7:0] exp, input string tag);
        bit got;
        wait_rx(60000, got);
        check(got, {tag, " rx_req raised"}, int'(got), 1);
        if (got) begin
            check(rx_data == exp, {tag, " rx_data"}, int'(rx_data), int'(exp));
            rx_ack = 1'b1; cyc(1); rx_ack = 1'b0;
            check(!rx_req, "R6 rx_req cleared after ack", int'(rx_req), 0);
        end
    endtask

    task automatic tx_frame(input logic [7:0] v, input int nb, input int ns,
                            input int dv, input string tag);
        bit got = 1'b0;
        tx_byte = v; tx_req = 1'b1;
        for (int i = 0; i < 100 && !got; i++) begin
            cyc(1);
            if (tx_ack) got = 1'b1;
        end
        tx_req = 1'b0;
        check(got, {tag, " tx_ack seen"}, int'(got), 1);
        cyc(1);
        check(!tx_ack, "R2 tx_ack one cycle", int'(tx_ack), 0);
        cyc(dv / 2 - 1);
        check(ser_out == 1'b0, {tag, " start bit"}, int'(ser_out), 0);
        for (int i = 0; i < nb; i++) begin
            cyc(dv);
            check(ser_out == v[i], {tag, " data bit"}, int'(ser_out), int'(v[i]));
        end
        for (int i = 0; i < ns; i++) begin
            cyc(dv);
            check(ser_out == 1'b1, {tag, " stop bit"}, int'(ser_out), 1);
        end
        cyc(dv - dv / 2);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles >= 190000) begin
                n_checks++; n_fails++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, 190000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        bit got;
        logic [7:0] v;
        int dv, nb, ns, mode;
        void'($urandom(32'd1234));
        cyc(3);
        check(ser_out == 1'b1, "R1 ser_out idle", int'(ser_out), 1);
        check(!rx_req, "R1 rx_req low", int'(rx_req), 0);
        check(!tx_ack, "R1 tx_ack low", int'(tx_ack), 0);
        rst_n = 1'b1; cyc(3);
        check(ser_out == 1'b1, "R1 ser_out after reset", int'(ser_out), 1);

        // Directed receive, full byte
        cfg_div = 16'd12; cfg_nbits = 4'd8; cfg_nstop = 2'd1;
        send_frame(8'hC3, 8, 1, 12, 1'b1);
        take_rx(8'hC3, "R4");

        // Short word, upper bits zero
        cfg_nbits = 4'd5;
        send_frame(8'hFF, 5, 1, 12, 1'b1);
        take_rx(8'h1F, "R7");
        cfg_nbits = 4'd8;

        // Glitch rejection
        cfg_div = 16'd16;
        ser_in = 1'b0; cyc(3); ser_in = 1'b1; cyc(48);
        check(!rx_req, "R8 glitch ignored", int'(rx_req), 0);
        send_frame(8'h5A, 8, 1, 16, 1'b1);
        take_rx(8'h5A, "R8 after glitch");

        // Framing error
        send_frame(8'h81, 8, 1, 16, 1'b0); cyc(48);
        check(!rx_req, "R9 bad stop discarded", int'(rx_req), 0);

        // Hold while unacknowledged; later frame dropped
        send_frame(8'h3C, 8, 1, 16, 1'b1);
        wait_rx(100, got);
        check(got, "R5 first byte", int'(got), 1);
        send_frame(8'hE7, 8, 1, 16, 1'b1); cyc(32);
        check(rx_req && rx_data == 8'h3C, "R5 held byte", int'(rx_data), 8'h3C);
        rx_ack = 1'b1; cyc(1); rx_ack = 1'b0;
        check(!rx_req, "R6 released", int'(rx_req), 0);
        cyc(48);
        check(!rx_req, "R5 second frame dropped", int'(rx_req), 0);

        // Transmit with two stop bits and divisor clamp
        cfg_div = 16'd2; cfg_nstop = 2'd2; cfg_nbits = 4'd12;
        tx_frame(8'h96, 8, 2, 4, "R3 clamp");
        cfg_div = 16'd10; cfg_nstop = 2'd1; cfg_nbits = 4'd6;
        tx_frame(8'hA9, 6, 1, 10, "R2");

        // Loopback with ser_in held low
        loop_en = 1'b1; ser_in = 1'b0; cfg_nbits = 4'd8;
        tx_frame(8'h4B, 8, 1, 10, "R10 tx");
        take_rx(8'h4B, "R10");

        // Defaults through loopback
        cfg_div = 16'd0; cfg_nbits = 4'd0; cfg_nstop = 2'd0;
        tx_frame(8'hA5, 8, 1, 5208, "R3 default");
        take_rx(8'hA5, "R3 default rx");
        ser_in = 1'b1; cyc(2); loop_en = 1'b0; cyc(4);

        // Random mix
        for (int k = 0; k < 30; k++) begin
            v = 8'($urandom);
            dv = 6 + int'($urandom % 19);
            nb = 5 + int'($urandom % 4);
            ns = 1 + int'($urandom % 2);
            mode = int'($urandom % 3);
            cfg_div = 16'(dv); cfg_nbits = 4'(nb); cfg_nstop = 2'(ns);
            cyc(2);
            if (mode == 0) begin
                send_frame(v, nb, ns, dv, 1'b1);
                take_rx(masked(v, nb), "R4 random");
            end else if (mode == 1) begin
                tx_frame(v, nb, ns, dv, "R2 random");
            end else begin
                loop_en = 1'b1; ser_in = 1'b0;
                tx_frame(v, nb, ns, dv, "R10 random tx");
                take_rx(masked(v, nb), "R10 random");
                ser_in = 1'b1; cyc(2); loop_en = 1'b0; cyc(2);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule